// File: doc/BRIEF.md
# Multi-Channel Clock Selector, Divider and Gate Bank

The bank produces up to sixteen derived clock outputs from four shared source clocks. Each channel has three stages in series. A four-way selector picks one source. A power-of-two divider then divides it by 1, 2, 4 or 8. Last, a gate either passes the divided clock or holds the output at a constant 0.

Three shared control words configure all channels through a simple write/read port. The stop word has one bit per channel, and a set bit stops that channel. The source word and the divider word each have a two-bit field per channel. Rate rounding is done by software, and the block only applies the divider codes it is given.

The four sources are level signals that are oversampled by the system clock `clk_i`. Each source must stay high and low for at least one system clock period. All channel logic runs in the `clk_i` domain, and every output is a register.

Top module: `clkbank`

## Requirements
- R1: After a synchronous reset, the stop word reads back with one set bit per channel (0x0000FFFF for 16 channels), the source word and the divider word read 0, and every clock output is 0.
- R2: A write with `wr_en_i` high stores `wdata_i` into the word at byte address 0x0 (stop), 0x4 (source) or 0x8 (divider). Bits with no channel behind them are stored and read as 0. `rdata_o` returns the word at `addr_i` one cycle after the address is presented, and shows its value from before that clock edge.
- R3: A write to any other address changes no word, and a read of any other address returns 0.
- R4: Channel i takes source j, where j is the value of source word bits [2i+1:2i].
- R5: Divider word bits [2i+1:2i] hold an exponent n, and channel i divides its selected source by 2^n. For n = 0 the divided clock is the sampled source level. For n > 0 it is bit n-1 of a three-bit counter that advances on each sampled rising edge of the selected source.
- R6: While stop bit i is set, output i is 0 from the next cycle onward.
- R7: After stop bit i is cleared, output i stays 0 until the divided clock is seen rising. It then follows the divided clock, so no shortened first pulse is produced.
- R8: In the cycle after channel i's source field changes, output i is 0, and its divide counter restarts from zero.
- R9: Sources pass through one sampling register. Output i is registered and reflects the channel's state with one cycle of latency from the sampled source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than every source |
| rst_i | input | 1 | Synchronous active-high reset |
| src_clk_i | input | 4 | Four source clock levels |
| wr_en_i | input | 1 | Write strobe for the control words |
| addr_i | input | 4 | Byte address of the control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the address |
| clk_o | output | NUM_CH (16) | Derived clock outputs, one per channel |

## Verification
A read result appears one edge after its address, so each readback is sampled at the falling edge that follows that edge. A written word governs the channels from the edge after the write. A source level reaches an output two edges later: one edge for the sampling register and one for the output register. The bench's reference model applies these delays itself and is compared with all outputs at every falling edge. Because of that, changes to the source word, stop bits and divider codes are checked in the exact cycle they are due.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;

    localparam int MAX_CH = 16;
    localparam int SRC_N  = 4;
    localparam int SEL_W  = $clog2(SRC_N);
    localparam int DIV_W  = 2;
    localparam int CNT_W  = (1 << DIV_W) - 1;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] STOP_ADDR = 4'h0;
    localparam logic [ADDR_W-1:0] SRC_ADDR  = 4'h4;
    localparam logic [ADDR_W-1:0] DIV_ADDR  = 4'h8;

    typedef enum logic [1:0] {
        WORD_NONE,
        WORD_STOP,
        WORD_SRC,
        WORD_DIV
    } word_sel_e;

    typedef struct packed {
        logic             stop;
        logic [SEL_W-1:0] src;
        logic [DIV_W-1:0] dexp;
    } chan_cfg_t;

    typedef struct packed {
        logic             sel_d;
        logic             div_d;
        logic             run;
        logic [SEL_W-1:0] src_d;
        logic [CNT_W-1:0] cnt;
    } chan_state_t;

    function automatic word_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            STOP_ADDR: return WORD_STOP;
            SRC_ADDR:  return WORD_SRC;
            DIV_ADDR:  return WORD_DIV;
            default:   return WORD_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] low_ones(input int n);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int k = 0; k < DATA_W; k++) begin
            if (k < n) m[k] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic div_tap(input logic lvl,
                                     input logic [CNT_W-1:0] cnt,
                                     input logic [DIV_W-1:0] e);
        logic t;
        t = lvl;
        for (int k = 1; k <= CNT_W; k++) begin
            if (e == DIV_W'(k)) t = cnt[k-1];
        end
        return t;
    endfunction

endpackage

// File: rtl/clkbank_regs.sv
module clkbank_regs
    import clkbank_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     wr_en_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [DATA_W-1:0]        wdata_i,
    output logic [DATA_W-1:0]        rdata_o,
    output chan_cfg_t [NUM_CH-1:0]   cfg_o
);

    localparam logic [DATA_W-1:0] STOP_MASK  = low_ones(NUM_CH);
    localparam logic [DATA_W-1:0] FIELD_MASK = low_ones(SEL_W * NUM_CH);
    localparam logic [DATA_W-1:0] DIV_MASK   = low_ones(DIV_W * NUM_CH);

    logic [DATA_W-1:0] stop_q;
    logic [DATA_W-1:0] src_q;
    logic [DATA_W-1:0] div_q;
    word_sel_e         wsel;

    assign wsel = decode_addr(addr_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stop_q  <= STOP_MASK;
            src_q   <= '0;
            div_q   <= '0;
            rdata_o <= '0;
        end else begin
            if (wr_en_i) begin
                case (wsel)
                    WORD_STOP: stop_q <= wdata_i & STOP_MASK;
                    WORD_SRC:  src_q  <= wdata_i & FIELD_MASK;
                    WORD_DIV:  div_q  <= wdata_i & DIV_MASK;
                    default:   ;
                endcase
            end
            case (wsel)
                WORD_STOP: rdata_o <= stop_q;
                WORD_SRC:  rdata_o <= src_q;
                WORD_DIV:  rdata_o <= div_q;
                default:   rdata_o <= '0;
            endcase
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_cfg
        assign cfg_o[i].stop = stop_q[i];
        assign cfg_o[i].src  = src_q[SEL_W*i +: SEL_W];
        assign cfg_o[i].dexp = div_q[DIV_W*i +: DIV_W];
    end

    // R2: a stop-word write lands, masked to existing channels
    assert_stop_write_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wsel == WORD_STOP) |=> (stop_q == ($past(wdata_i) & STOP_MASK)));

    // R2: bits without a channel behind them read as zero
    assert_stop_unused_zero_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (wsel == WORD_STOP) |=> ((rdata_o & ~STOP_MASK) == '0));

    // R3: reads of unmapped addresses give zero
    assert_unmapped_read_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wsel == WORD_NONE) |=> (rdata_o == '0));

    // R3: writes to unmapped addresses leave all words alone
    assert_unmapped_write_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (wr_en_i && wsel == WORD_NONE) |=> ($stable(stop_q) && $stable(src_q) && $stable(div_q)));

endmodule

// File: rtl/clkbank_chan.sv
module clkbank_chan
    import clkbank_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SRC_N-1:0] src_i,
    input  chan_cfg_t        cfg_i,
    output logic             clk_o
);

    chan_state_t st_q;
    chan_state_t st_d;
    logic        sel;
    logic        sel_rise;
    logic        dclk;
    logic        dclk_rise;
    logic        swap;
    logic        out_d;

    always_comb begin
        sel       = src_i[cfg_i.src];
        sel_rise  = sel & ~st_q.sel_d;
        swap      = (cfg_i.src != st_q.src_d);
        dclk      = div_tap(sel, st_q.cnt, cfg_i.dexp);
        dclk_rise = dclk & ~st_q.div_d;

        st_d       = st_q;
        st_d.sel_d = sel;
        st_d.div_d = dclk;
        st_d.src_d = cfg_i.src;
        if (swap) begin
            st_d.cnt = '0;
        end else if (sel_rise) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (cfg_i.stop) begin
            st_d.run = 1'b0;
        end else if (dclk_rise) begin
            st_d.run = 1'b1;
        end
        out_d = ~swap & st_d.run & dclk;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= '0;
            clk_o <= 1'b0;
        end else begin
            st_q  <= st_d;
            clk_o <= out_d;
        end
    end

    // R6: a stopped channel is low on the next cycle
    assert_stopped_low_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_i.stop |=> !clk_o);

    // R8: a source change forces one low cycle
    assert_switch_low_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        swap |=> !clk_o);

    // R7: an idle channel only starts on a divided-clock rise
    assert_start_on_rise_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.run && !dclk_rise) |=> !clk_o);

    // R5: the divide counter moves only on a source rise or a switch
    assert_count_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sel_rise && !swap) |=> $stable(st_q.cnt));

endmodule

// File: rtl/clkbank.sv
module clkbank
    import clkbank_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [3:0]        src_clk_i,
    input  logic              wr_en_i,
    input  logic [3:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic [NUM_CH-1:0] clk_o
);

    logic [SRC_N-1:0]      src_smp_q;
    chan_cfg_t [NUM_CH-1:0] cfg;

    initial begin
        if (NUM_CH < 1 || NUM_CH > MAX_CH) begin
            $error("NUM_CH out of range");
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) src_smp_q <= '0;
        else       src_smp_q <= src_clk_i;
    end

    clkbank_regs #(.NUM_CH(NUM_CH)) u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o),
        .cfg_o   (cfg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        clkbank_chan u_chan (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .src_i (src_smp_q),
            .cfg_i (cfg[i]),
            .clk_o (clk_o[i])
        );
    end

endmodule

// File: tb/clkbank_tb.sv
`timescale 1ns/1ps
module clkbank_tb;

    localparam int NCH = 16;

    logic           clk = 1'b0;
    logic           rst;
    logic [3:0]     src_clk;
    logic           wr_en;
    logic [3:0]     addr;
    logic [31:0]    wdata;
    logic [31:0]    rdata;
    logic [NCH-1:0] clk_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit cmp_en = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    clkbank #(.NUM_CH(NCH)) u_dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .src_clk_i (src_clk),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .clk_o     (clk_out)
    );

    // free-running source waveforms, half periods 2, 3, 4 and 6 cycles
    int half [4] = '{2, 3, 4, 6};
    int scnt [4] = '{0, 0, 0, 0};
    initial src_clk = 4'b0;
    always @(negedge clk) begin
        for (int s = 0; s < 4; s++) begin
            scnt[s] = scnt[s] + 1;
            if (scnt[s] >= half[s]) begin
                scnt[s] = 0;
                src_clk[s] = ~src_clk[s];
            end
        end
    end

    // behavioural reference model
    int unsigned m_stop, m_src, m_div;
    int          m_smp;
    int          m_psel [NCH];
    int          m_pdiv [NCH];
    int          m_run  [NCH];
    int          m_prev [NCH];
    int          m_cnt  [NCH];
    logic [NCH-1:0] m_out;

    always @(posedge clk) begin
        if (rst) begin
            m_stop = 32'h0000FFFF; m_src = 0; m_div = 0; m_smp = 0; m_out = '0;
            for (int c = 0; c < NCH; c++) begin
                m_psel[c] = 0; m_pdiv[c] = 0; m_run[c] = 0; m_prev[c] = 0; m_cnt[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                int sf, df, sb, lvl, dc, rise, runn, sw;
                sf  = (m_src >> (2*c)) & 3;
                df  = (m_div >> (2*c)) & 3;
                sb  = (m_stop >> c) & 1;
                sw  = (sf != m_prev[c]);
                lvl = (m_smp >> sf) & 1;
                dc  = (df == 0) ? lvl : ((m_cnt[c] >> (df - 1)) & 1);
                rise = dc && !m_pdiv[c];
                runn = sb ? 0 : (m_run[c] || rise);
                m_out[c] = (!sw && runn && dc);
                if (sw) m_cnt[c] = 0;
                else if (lvl && !m_psel[c]) m_cnt[c] = (m_cnt[c] + 1) % 8;
                m_psel[c] = lvl; m_pdiv[c] = dc; m_run[c] = runn; m_prev[c] = sf;
            end
            m_smp = src_clk;
            if (wr_en) begin
                case (addr)
                    4'h0: m_stop = wdata & 32'h0000FFFF;
                    4'h4: m_src  = wdata;
                    4'h8: m_div  = wdata;
                    default: ;
                endcase
            end
        end
    end

    // R4 R5 R6 R7 R8 R9: every output compared each cycle
    always @(negedge clk) begin
        if (cmp_en) begin
            checks++;
            if (clk_out !== m_out) begin
                errors++;
                $display("FAIL %s: clk_o actual %h expected %h at cycle %0d",
                         cur_req, clk_out, m_out, cyc);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'hF;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        @(negedge clk);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s: read addr %h actual %h expected %h", req, a, rdata, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = 4'h0; wdata = '0;
        @(posedge clk);
        cmp_en = 1;
        run(3);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        cur_req = "R1";
        rd_chk(4'h0, 32'h0000FFFF, "R1");
        rd_chk(4'h4, 32'h0, "R1");
        rd_chk(4'h8, 32'h0, "R1");

        // R2: stores and readback, unused stop bits zero
        cur_req = "R2";
        wr(4'h4, 32'hE4E4_1B1B);
        rd_chk(4'h4, 32'hE4E4_1B1B, "R2");
        wr(4'h8, 32'h1234_ABCD);
        rd_chk(4'h8, 32'h1234_ABCD, "R2");
        wr(4'h0, 32'hFFFF_FFFF);
        rd_chk(4'h0, 32'h0000FFFF, "R2");

        // R3: unmapped addresses
        cur_req = "R3";
        wr(4'hC, 32'hDEAD_BEEF);
        rd_chk(4'hC, 32'h0, "R3");
        wr(4'h2, 32'h0);
        rd_chk(4'h0, 32'h0000FFFF, "R3");
        rd_chk(4'h4, 32'hE4E4_1B1B, "R3");

        // R4 R5 R7: sources and dividers mixed, then ungate
        cur_req = "R4/R5/R7";
        wr(4'h4, 32'hE4E4_E4E4);
        wr(4'h8, 32'hFA50_A5F0);
        wr(4'h0, 32'h0);
        run(300);

        // R8: source switches on running channels
        cur_req = "R8";
        wr(4'h4, 32'h1B1B_4E4E);
        run(200);
        wr(4'h4, 32'h1B1B_4E4F);
        run(100);

        // R6: partial and full stop
        cur_req = "R6";
        wr(4'h0, 32'h0000_A5A5);
        run(200);
        wr(4'h0, 32'h0000_FFFF);
        run(50);
        checks++;
        if (clk_out !== '0) begin
            errors++;
            $display("FAIL R6: clk_o actual %h expected 0000", clk_out);
        end

        // R5 R9: all channels on one source, divide by 8 then by 1
        cur_req = "R5/R9";
        wr(4'h4, 32'h0);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'h0, 32'h0);
        run(300);
        wr(4'h8, 32'h0);
        run(100);
        wr(4'h0, 32'h0000_00FF);
        run(60);

        @(negedge clk);
        cmp_en = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule